// File: doc/BRIEF.md
# One's Complement Subtractive Adder

This block adds or subtracts two 16-bit one's complement words. Bit 15 is the sign, and a negative value is the bitwise inverse of its magnitude. Both operations go through one unsigned subtractor. An add first inverts the addend and then subtracts it from the augend. A subtract passes the subtrahend through unchanged. When the subtractor needs a borrow out of the top bit, one more is taken from the difference (end-around borrow). With this scheme the all-ones pattern (negative zero) appears for only two operand pairs.

The path from operands to result is combinational, and so is the overflow pulse. The only state is a sticky overflow indicator. A cycle marked by the execute input sets it whenever that cycle overflows. A test strobe shows the indicator's value in that cycle and clears it at the next clock edge, unless an overflow arrives in the same cycle.

Top module: `ocadd_top`

## Requirements
- R1: With op_sub low (add), sum_out is the one's complement sum of opd_a and opd_b, produced by subtracting the inverse of opd_b from opd_a with end-around borrow.
- R2: With op_sub high (subtract), sum_out is opd_a minus opd_b, formed with end-around borrow and without inverting opd_b.
- R3: Adding a value to its own inverse gives positive zero 0x0000, for example 0x4321 plus 0xBCDE.
- R4: sum_out is 0xFFFF (negative zero) only for 0xFFFF plus 0xFFFF and for 0xFFFF minus 0x0000. Adding 0xFFFF and 0x0000 gives 0x0000.
- R5: An add overflows when both operands carry the same sign and the result's sign differs from it. The wrapped value is then on sum_out, for example 0x7FFF plus 0x0001 gives 0x8000.
- R6: A subtract overflows when the operand signs differ and the result's sign differs from that of opd_a, for example 0x8000 minus 0x0001 gives 0x7FFF.
- R7: An add of one non-negative-signed and one negative-signed operand never raises ovf_pulse.
- R8: ovf_pulse is high exactly in a cycle with exec high whose operation overflows. The indicator ovf_flag is set at the following clock edge.
- R9: Once set, ovf_flag stays set across any number of cycles in which ovf_test is low.
- R10: In a cycle with ovf_test high, ovf_flag shows the indicator's current state, and the indicator reads 0 after that clock edge.
- R11: If ovf_test and an overflowing executed operation fall in the same cycle, ovf_flag is 1 after that edge: the set wins.
- R12: An overflowing operand pair with exec low leaves ovf_pulse low and does not change ovf_flag. A synchronous active-high rst clears ovf_flag to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec | input | 1 | Marks the current operands as an operation that counts toward the indicator |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| opd_a | input | 16 | Augend or minuend |
| opd_b | input | 16 | Addend or subtrahend |
| ovf_test | input | 1 | Test strobe: read the indicator and clear it |
| sum_out | output | 16 | One's complement result (combinational) |
| ovf_pulse | output | 1 | Overflow of the current executed operation (combinational) |
| ovf_flag | output | 1 | Sticky overflow indicator |

## Verification
An overflowing executed operation and a test strobe can occur in the same cycle. One of them sets the indicator and the other clears it. The bench forces this collision on purpose in a directed step, once with the indicator already set and once with it clear. Random stimulus also raises exec and ovf_test together often enough that the collision recurs many times. In every cycle the bench compares ovf_flag against its own model, in which a set takes priority over a clear, and it checks the value seen during the test cycle against the state before the edge.

// File: rtl/ocadd_pkg.sv
package ocadd_pkg;
    localparam int unsigned WORD_W = 16;
    localparam int unsigned SIGN_B = WORD_W - 1;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

    typedef struct packed {
        word_t minu;
        word_t subt;
    } sub_pair_t;

    typedef struct packed {
        logic  borrow;
        word_t diff;
    } sub_res_t;

    function automatic logic sign_of(input word_t w);
        return w[SIGN_B];
    endfunction
endpackage

// File: rtl/ocadd_prep.sv
module ocadd_prep
    import ocadd_pkg::*;
(
    input  op_e       op,
    input  word_t     a,
    input  word_t     b,
    output sub_pair_t pair
);
    always_comb begin
        pair.minu = a;
        pair.subt = (op == OP_ADD) ? ~b : b;
    end
endmodule

// File: rtl/ocadd_core.sv
module ocadd_core
    import ocadd_pkg::*;
(
    input  sub_pair_t pair,
    output sub_res_t  res
);
    localparam int unsigned EXT_W = WORD_W + 1;
    logic [EXT_W-1:0] raw;

    always_comb begin
        raw        = {1'b0, pair.minu} - {1'b0, pair.subt};
        res.borrow = raw[WORD_W];
        res.diff   = res.borrow ? (raw[WORD_W-1:0] - word_t'(1)) : raw[WORD_W-1:0];
    end
endmodule

// File: rtl/ocadd_ovf.sv
module ocadd_ovf
    import ocadd_pkg::*;
(
    input  sub_pair_t pair,
    input  word_t     diff,
    output logic      ovf
);
    always_comb begin
        ovf = (sign_of(pair.minu) != sign_of(pair.subt)) &&
              (sign_of(diff) != sign_of(pair.minu));
    end
endmodule

// File: rtl/ocadd_sticky.sv
module ocadd_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst)        flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_o); // R8
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !clr_i) |=> flag_o); // R9
    AST_TEST_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !flag_o); // R10
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (clr_i && set_i) |=> flag_o); // R11
endmodule

// File: rtl/ocadd_top.sv
module ocadd_top
    import ocadd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              exec,
    input  logic              op_sub,
    input  logic [WORD_W-1:0] opd_a,
    input  logic [WORD_W-1:0] opd_b,
    input  logic              ovf_test,
    output logic [WORD_W-1:0] sum_out,
    output logic              ovf_pulse,
    output logic              ovf_flag
);
    op_e       op;
    sub_pair_t pair;
    sub_res_t  res;
    logic      ovf_raw;

    assign op = op_sub ? OP_SUB : OP_ADD;

    ocadd_prep u_prep (.op(op), .a(opd_a), .b(opd_b), .pair(pair));
    ocadd_core u_core (.pair(pair), .res(res));
    ocadd_ovf  u_ovf  (.pair(pair), .diff(res.diff), .ovf(ovf_raw));

    assign sum_out   = res.diff;
    assign ovf_pulse = exec & ovf_raw;

    ocadd_sticky u_sticky (
        .clk(clk), .rst(rst), .set_i(ovf_pulse), .clr_i(ovf_test), .flag_o(ovf_flag)
    );

    AST_NEG_ZERO_RARE: assert property (@(posedge clk) disable iff (rst)
        (sum_out == '1) |-> (opd_a == '1 && (op_sub ? (opd_b == '0) : (opd_b == '1)))); // R4
    AST_MIXED_ADD_SAFE: assert property (@(posedge clk) disable iff (rst)
        (!op_sub && (opd_a[SIGN_B] != opd_b[SIGN_B])) |-> !ovf_pulse); // R7
    AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
        !exec |-> !ovf_pulse); // R12
    AST_ADD_INVERSE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!op_sub && (opd_b == ~opd_a)) |-> (sum_out == '0)); // R3
endmodule

// File: tb/sim_ocadd_top.sv
module sim_ocadd_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exec = 1'b0;
    logic        op_sub = 1'b0;
    logic [15:0] opd_a = '0;
    logic [15:0] opd_b = '0;
    logic        ovf_test = 1'b0;
    logic [15:0] sum_out;
    logic        ovf_pulse;
    logic        ovf_flag;

    int total = 0;
    int bad = 0;
    bit exp_flag = 1'b0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    ocadd_top u0 (
        .clk(clk), .rst(rst), .exec(exec), .op_sub(op_sub), .opd_a(opd_a),
        .opd_b(opd_b), .ovf_test(ovf_test), .sum_out(sum_out),
        .ovf_pulse(ovf_pulse), .ovf_flag(ovf_flag)
    );

    function automatic int to_int(input logic [15:0] v);
        logic [15:0] m;
        m = ~v;
        return v[15] ? -int'(m) : int'(v);
    endfunction

    function automatic logic [15:0] from_int(input int x);
        logic [15:0] m;
        if (x >= 0) return x[15:0];
        m = 16'((-x));
        return ~m;
    endfunction

    function automatic logic [16:0] model(input logic [15:0] a, input logic [15:0] b,
                                          input bit sub);
        int s;
        bit ov;
        if (a == 16'hFFFF && ((!sub && b == 16'hFFFF) || (sub && b == 16'h0000)))
            return {1'b0, 16'hFFFF};
        s  = sub ? to_int(a) - to_int(b) : to_int(a) + to_int(b);
        ov = (s > 32767) || (s < -32767);
        if (s > 32767)  s = s - 65535;
        if (s < -32767) s = s + 65535;
        return {ov, from_int(s)};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic [15:0] a, input logic [15:0] b, input bit sub,
                        input bit ex, input bit tst, input string req);
        logic [16:0] m;
        @(negedge clk);
        opd_a = a; opd_b = b; op_sub = sub; exec = ex; ovf_test = tst;
        #5;
        m = model(a, b, sub);
        chk(req, int'(sum_out), int'(m[15:0]));
        chk(req, int'(ovf_pulse), int'(ex & m[16]));
        chk({req, " flag"}, int'(ovf_flag), int'(exp_flag));
        @(posedge clk);
        if (ex && m[16]) exp_flag = 1'b1;
        else if (tst)    exp_flag = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1 chk("R12 reset", int'(ovf_flag), 0);
        // directed
        step(16'h4321, 16'hBCDE, 0, 1, 0, "R3");
        step(16'h0005, 16'hFFFA, 0, 1, 0, "R3");
        step(16'hFFFF, 16'hFFFF, 0, 1, 0, "R4");
        step(16'hFFFF, 16'h0000, 1, 1, 0, "R4");
        step(16'hFFFF, 16'h0000, 0, 1, 0, "R4");
        step(16'h1234, 16'h0101, 0, 1, 0, "R1");
        step(16'h1234, 16'h0101, 1, 1, 0, "R2");
        step(16'h0003, 16'hFFF7, 1, 1, 0, "R2");
        step(16'h7FFF, 16'h8001, 0, 0, 0, "R12");
        step(16'h7FFF, 16'h0001, 0, 0, 0, "R12");
        step(16'h7FFF, 16'h8000, 0, 1, 0, "R7");
        step(16'h7FFF, 16'h0001, 0, 1, 0, "R5");
        step(16'h0000, 16'h0000, 0, 0, 0, "R9");
        step(16'h0000, 16'h0000, 0, 0, 0, "R9");
        step(16'h0000, 16'h0000, 0, 0, 1, "R10");
        step(16'h0000, 16'h0000, 0, 0, 0, "R10");
        step(16'h8000, 16'h0001, 1, 1, 1, "R6 R11");
        step(16'h8000, 16'hFFFE, 0, 1, 1, "R5 R11");
        step(16'h0000, 16'h0000, 0, 0, 1, "R11");
        step(16'h0000, 16'h0000, 0, 0, 0, "R10");
        // random
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] ra, rb;
            ra = 16'($urandom);
            rb = 16'($urandom);
            if (($urandom % 8) == 0) rb = ~ra;
            if (($urandom % 16) == 0) ra = 16'hFFFF;
            step(ra, rb, 1'($urandom), ($urandom % 4) != 0, ($urandom % 5) == 0,
                 "R1 R2 R5 R6 R8");
        end
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule